// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a bank of already-sampled input levels, one bit per pin, and turns the activity on each pin into a sticky interrupt status bit. Each pin has its own trigger setting. It can fire on a rising edge, on a falling edge or on both edges, or it can fire while the pin is high or while it is low. A status bit can only become set while that pin's enable bit is 1. The single interrupt output is the OR of every status bit.

Software uses a small register port to program the block. There is one enable register and three trigger-setting registers. The polarity register selects rising or high. The mode register selects level or edge. The dual register selects both edges. Software reads the status register and clears it by writing ones. The register port is plain control: a write strobe, an address and write data. Read data is combinational from the address. There is no valid/ready flow, because the block takes no data stream.

Edge detection compares each input with a registered copy of the previous sample. On reset that copy is loaded from the live input, so a pin that is already high when reset is released does not report an edge.

Top module: `pin_irq_detector`

## Requirements
- R1: The register byte offsets are: enable at 0x00, polarity at 0x04, mode at 0x08, dual at 0x0C and status at 0x10. A read returns the addressed register. Any other offset reads as zero.
- R2: After reset, the enable, polarity, mode, dual and status registers are all zero and `irq` is low. A pin that is high during reset produces no event when reset is released.
- R3: Polarity bit 0 selects a falling edge or a low level. Polarity bit 1 selects a rising edge or a high level.
- R4: Mode bit 0 selects edge detection. Mode bit 1 selects level detection, which raises status on every cycle the level is active.
- R5: In edge mode, dual bit 1 detects both edges and ignores polarity. Dual bit 0 detects only the single edge chosen by polarity.
- R6: Status bits are sticky. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: A status bit is never set while its enable bit is 0. Clearing an enable bit does not clear status that is already set.
- R8: `irq` is high exactly when at least one status bit is set.
- R9: In level mode, a clear written while the level is still active leaves the bit set. Once the level has gone away, the clear takes effect.
- R10: When a clear and a new event reach the same bit in the same cycle, the bit stays set.
- R11: An event on the input in one cycle shows up in status, and in `irq`, after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 32 | Sampled pin levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check three status properties on every cycle: a set bit only goes away through a write-one clear, a new bit appears only under enable, and a clear loses to a same-cycle event. They also check that `irq` follows the status register. Whether each combination of polarity, mode and dual picks the right edge or level can only be shown by the bench's scenarios, which compare against the reference model on every clock. The same applies to the absence of a spurious edge after reset and to the register decoding.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int unsigned REG_AW = 5;
  localparam logic [REG_AW-1:0] OFS_ENABLE = 5'h00;
  localparam logic [REG_AW-1:0] OFS_POLAR  = 5'h04;
  localparam logic [REG_AW-1:0] OFS_MODE   = 5'h08;
  localparam logic [REG_AW-1:0] OFS_DUAL   = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_STATUS = 5'h10;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ENABLE, SEL_POLAR, SEL_MODE, SEL_DUAL, SEL_STATUS
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [REG_AW-1:0] a);
    case (a)
      OFS_ENABLE: decode = SEL_ENABLE;
      OFS_POLAR:  decode = SEL_POLAR;
      OFS_MODE:   decode = SEL_MODE;
      OFS_DUAL:   decode = SEL_DUAL;
      OFS_STATUS: decode = SEL_STATUS;
      default:    decode = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pid_cfg_regs.sv
module pid_cfg_regs
  import pid_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  reg_sel_e         sel,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] en_q,
  output logic [NPINS-1:0] polar_q,
  output logic [NPINS-1:0] mode_q,
  output logic [NPINS-1:0] dual_q,
  output logic [NPINS-1:0] clr_mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      polar_q <= '0;
      mode_q  <= '0;
      dual_q  <= '0;
    end else if (wr) begin
      case (sel)
        SEL_ENABLE: en_q    <= wdata;
        SEL_POLAR:  polar_q <= wdata;
        SEL_MODE:   mode_q  <= wdata;
        SEL_DUAL:   dual_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    clr_mask = (wr && sel == SEL_STATUS) ? wdata : '0;
  end
endmodule

// File: rtl/pid_trigger.sv
module pid_trigger #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] polar,
  input  logic [NPINS-1:0] mode,
  input  logic [NPINS-1:0] dual,
  output logic [NPINS-1:0] hit
);
  logic [NPINS-1:0] prev_q;

  // previous sample loads from the live input during reset: no false edge
  always_ff @(posedge clk) begin
    prev_q <= pin_in;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, lvl_hit, edg_hit;
    always_comb begin
      rise    = pin_in[i] & ~prev_q[i];
      fall    = ~pin_in[i] & prev_q[i];
      lvl_hit = polar[i] ? pin_in[i] : ~pin_in[i];
      if (dual[i]) edg_hit = rise | fall;
      else         edg_hit = polar[i] ? rise : fall;
      hit[i]  = rst_n & (mode[i] ? lvl_hit : edg_hit);
    end
  end
endmodule

// File: rtl/pid_status.sv
module pid_status #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] hit,
  input  logic [NPINS-1:0] en,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] status_q,
  output logic             irq_q
);
  logic [NPINS-1:0] evt;
  logic [NPINS-1:0] status_d;

  always_comb begin
    evt      = hit & en;
    status_d = (status_q & ~clr_mask) | evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= |status_d;
    end
  end

  // R6
  sticky_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q) & ~$past(clr_mask) & ~status_q) == '0));

  // R7
  set_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(en)) == '0));

  // R10
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit) & $past(en) & $past(clr_mask) & ~status_q) == '0));
endmodule

// File: rtl/pin_irq_detector.sv
module pin_irq_detector
  import pid_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  output logic              irq
);
  reg_sel_e         sel;
  logic [NPINS-1:0] en_q, polar_q, mode_q, dual_q, clr_mask, hit, status_q;

  assign sel = decode(reg_addr);

  pid_cfg_regs #(.NPINS(NPINS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(sel), .wdata(reg_wdata),
    .en_q(en_q), .polar_q(polar_q), .mode_q(mode_q), .dual_q(dual_q),
    .clr_mask(clr_mask)
  );

  pid_trigger #(.NPINS(NPINS)) u_trig (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .polar(polar_q),
    .mode(mode_q), .dual(dual_q), .hit(hit)
  );

  pid_status #(.NPINS(NPINS)) u_sts (
    .clk(clk), .rst_n(rst_n), .hit(hit), .en(en_q), .clr_mask(clr_mask),
    .status_q(status_q), .irq_q(irq)
  );

  always_comb begin
    case (sel)
      SEL_ENABLE: reg_rdata = en_q;
      SEL_POLAR:  reg_rdata = polar_q;
      SEL_MODE:   reg_rdata = mode_q;
      SEL_DUAL:   reg_rdata = dual_q;
      SEL_STATUS: reg_rdata = status_q;
      default:    reg_rdata = '0;
    endcase
  end

  // R8
  irq_tracks_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|status_q));
endmodule

// File: tb/pin_irq_detector_tb.sv
module pin_irq_detector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = 32'h21;
  logic        wr = 1'b0;
  logic [4:0]  addr = 5'h10;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pin_irq_detector u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_en, m_pol, m_mode, m_dual, m_sts, m_prev;
  always @(posedge clk) begin
    logic [31:0] ev;
    if (!rst_n) begin
      m_en = 0; m_pol = 0; m_mode = 0; m_dual = 0; m_sts = 0;
    end else begin
      ev = 0;
      for (int i = 0; i < 32; i++) begin
        bit r, f, h;
        r = pins[i] && !m_prev[i];
        f = !pins[i] && m_prev[i];
        if (m_mode[i]) h = (pins[i] == m_pol[i]);
        else if (m_dual[i]) h = r || f;
        else h = m_pol[i] ? r : f;
        ev[i] = h && m_en[i];
      end
      if (wr && addr == 5'h10) m_sts = m_sts & ~wdata;
      m_sts = m_sts | ev;
      if (wr) begin
        if (addr == 5'h00) m_en = wdata;
        if (addr == 5'h04) m_pol = wdata;
        if (addr == 5'h08) m_mode = wdata;
        if (addr == 5'h0C) m_dual = wdata;
      end
    end
    m_prev = pins;
  end

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return m_en;
      5'h04: return m_pol;
      5'h08: return m_mode;
      5'h0C: return m_dual;
      5'h10: return m_sts;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // R11: model comparison on every clock
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      check("R11 model rdata", rdata, m_read(addr));
      check("R8 model irq", {31'b0, irq}, {31'b0, m_sts != 0});
    end
  end

  task automatic drv(input logic w, input logic [4:0] a, input logic [31:0] d, input logic [31:0] p);
    @(negedge clk);
    wr = w; addr = a; wdata = d; pins = p;
    #1;
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
    drv(1'b0, a, 32'h0, pins);
    check(tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    rd("R2 status after reset", 5'h10, 32'h0);
    check("R2 irq after reset", {31'b0, irq}, 32'h0);
    rd("R2 polarity after reset", 5'h04, 32'h0);
    drv(1'b1, 5'h00, 32'hFFFF_FFDF, 32'h21);
    rd("R2 no edge from high pin", 5'h10, 32'h0);
    drv(1'b0, 5'h10, 0, 32'h20);
    rd("R3 falling edge default", 5'h10, 32'h1);
    check("R8 irq high", {31'b0, irq}, 32'h1);
    drv(1'b0, 5'h10, 0, 32'h00);
    rd("R7 masked pin stays clear", 5'h10, 32'h1);
    drv(1'b1, 5'h10, 32'h0, 32'h00);
    rd("R6 write zero no effect", 5'h10, 32'h1);
    drv(1'b1, 5'h10, 32'h1, 32'h00);
    rd("R6 write one clears", 5'h10, 32'h0);
    check("R8 irq low", {31'b0, irq}, 32'h0);
    drv(1'b1, 5'h04, 32'h2, 32'h00);
    drv(1'b0, 5'h10, 0, 32'h02);
    rd("R3 rising edge", 5'h10, 32'h2);
    drv(1'b1, 5'h10, 32'h2, 32'h02);
    drv(1'b0, 5'h10, 0, 32'h00);
    rd("R3 falling ignored in rising mode", 5'h10, 32'h0);
    drv(1'b1, 5'h10, 32'h2, 32'h02);
    rd("R10 clear loses to event", 5'h10, 32'h2);
    drv(1'b1, 5'h10, 32'h2, 32'h02);
    rd("R6 clear after event", 5'h10, 32'h0);
    drv(1'b1, 5'h0C, 32'h4, 32'h02);
    drv(1'b0, 5'h10, 0, 32'h06);
    rd("R5 dual rising", 5'h10, 32'h4);
    drv(1'b1, 5'h10, 32'h4, 32'h06);
    drv(1'b0, 5'h10, 0, 32'h02);
    rd("R5 dual falling", 5'h10, 32'h4);
    drv(1'b1, 5'h10, 32'h4, 32'h02);
    drv(1'b1, 5'h04, 32'hA, 32'h02);
    drv(1'b1, 5'h08, 32'h8, 32'h02);
    drv(1'b0, 5'h10, 0, 32'h0A);
    rd("R4 level high", 5'h10, 32'h8);
    drv(1'b1, 5'h10, 32'h8, 32'h0A);
    rd("R9 clear while level active", 5'h10, 32'h8);
    drv(1'b0, 5'h10, 0, 32'h02);
    drv(1'b1, 5'h10, 32'h8, 32'h02);
    rd("R9 clear after level gone", 5'h10, 32'h0);
    drv(1'b1, 5'h08, 32'h18, 32'h02);
    drv(1'b0, 5'h10, 0, 32'h02);
    rd("R4 level low", 5'h10, 32'h10);
    drv(1'b1, 5'h00, 32'h0, 32'h02);
    rd("R7 disable keeps status", 5'h10, 32'h10);
    rd("R1 mode offset", 5'h08, 32'h18);
    rd("R1 dual offset", 5'h0C, 32'h4);
    rd("R1 polarity offset", 5'h04, 32'hA);
    rd("R1 enable offset", 5'h00, 32'h0);
    rd("R1 unused offset", 5'h14, 32'h0);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule